// File: doc/BRIEF.md
# Receive Error Counter Bank with Maskable Interrupts

This block keeps three receive-side error tallies for an E1 framer. One 8-bit counter counts frame alignment errors. Two 16-bit counters count E-bit errors and CRC-4 errors. Each tally advances by one for every single-cycle error strobe it receives. The detectors that raise these strobes sit outside the block. Software reaches the counters through a simple byte-wide register port with write and read strobes. Through that port it can read a count, or preset or clear it.

Each counter drives two interrupt sources. The step source fires on every count, because every count flips the low bit. The wrap source fires when the count rolls from all ones to zero. A mask register enables each source on its own. An enabled source sets a sticky status bit, and software clears that bit by writing a one to it. A single active-high interrupt line is high while any status bit is set.

A wide counter is loaded in two writes. The low byte is written first and is held in a staging register. The high byte is written second, and both bytes enter the counter together on that write, so the counter never runs from a half-loaded value.

Top module: `perf_err_bank`

## Requirements
- R1: After reset every counter, the staging registers, the mask and the status register read zero, and `irq_o` is low.
- R2: The frame alignment counter is 8 bits wide. It adds one for each cycle in which `fas_err_i` is high, and it rolls from 8'hFF to 8'h00.
- R3: The E-bit counter and the CRC-4 counter are 16 bits wide. Each adds one per cycle in which its strobe (`ebit_err_i`, `crc_err_i`) is high, and each rolls from 16'hFFFF to 16'h0000.
- R4: Every count step raises that counter's step source. Status bit 0 belongs to the frame alignment counter, bit 2 to the E-bit counter and bit 4 to the CRC-4 counter.
- R5: A step from all ones to zero raises that counter's wrap source. Status bit 1 belongs to the frame alignment counter, bit 3 to the E-bit counter and bit 5 to the CRC-4 counter.
- R6: A source sets its status bit only when the mask bit at the same position is 1, using the mask value held before the edge. The mask is read and written at address 5, and bits 7:6 read zero.
- R7: Status is read at address 6. Writing there clears each bit written as 1 and leaves each bit written as 0 unchanged. A source that fires in the same cycle as the clear sets its bit.
- R8: `irq_o` is high in exactly the cycles in which at least one status bit is set, and it changes on the same clock edge as the status register.
- R9: Writing a low byte (address 1 or 3) changes only the staging register, and the counter keeps its value. Writing the high byte (address 2 or 4) loads {high byte, staged low byte} into the counter.
- R10: If a counter's strobe coincides with a write to any of that counter's addresses, the strobe is dropped: the write takes effect, there is no count step, and no interrupt source fires.
- R11: The address map is: 0 = frame alignment count, 1 and 2 = E-bit count low and high, 3 and 4 = CRC-4 count low and high, 5 = mask, 6 = status, 7 = reads zero. A read returns, one clock after `rd_en_i`, the value the register held before that edge. Reading a low byte returns the counter, not the staging register.
- R12: Writing address 0 loads the frame alignment counter directly with the written byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| fas_err_i | input | 1 | Frame alignment error strobe |
| ebit_err_i | input | 1 | E-bit error strobe |
| crc_err_i | input | 1 | CRC-4 error strobe |
| wr_en_i | input | 1 | Register write strobe |
| rd_en_i | input | 1 | Register read strobe |
| addr_i | input | 3 | Register address |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Registered read data |
| irq_o | output | 1 | Interrupt, high while any status bit is set |

## Verification
A counter that misses a step or steps twice shows up on the next read of its address, one clock after the read strobe. If the corresponding source is enabled, it shows up even sooner as a status bit that is missing or set wrongly, and `irq_o` carries that on the same edge. A staging register that leaks would appear as a counter value that changes after a low-byte write alone. A lost or duplicated wrap would leave the wrap status bit wrong after the roll-over cycle. The bench mirrors every counter, the staging registers, the mask and the status register in a model, and it compares `irq_o` after every cycle.

// File: rtl/perf_err_pkg.sv
package perf_err_pkg;
  localparam int DATA_W   = 8;
  localparam int ADDR_W   = 3;
  localparam int NUM_SRC  = 6;

  localparam logic [ADDR_W-1:0] A_FAS    = 3'd0;
  localparam logic [ADDR_W-1:0] A_EB_LO  = 3'd1;
  localparam logic [ADDR_W-1:0] A_EB_HI  = 3'd2;
  localparam logic [ADDR_W-1:0] A_CRC_LO = 3'd3;
  localparam logic [ADDR_W-1:0] A_CRC_HI = 3'd4;
  localparam logic [ADDR_W-1:0] A_MASK   = 3'd5;
  localparam logic [ADDR_W-1:0] A_STAT   = 3'd6;

  // status bit layout: even = count step, odd = wrap
  localparam int S_FAS_STEP = 0;
  localparam int S_FAS_WRAP = 1;
  localparam int S_EB_STEP  = 2;
  localparam int S_EB_WRAP  = 3;
  localparam int S_CRC_STEP = 4;
  localparam int S_CRC_WRAP = 5;
endpackage

// File: rtl/err_cnt.sv
module err_cnt #(
  parameter int W  = 16,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          inc,
  input  logic          wr_lo,
  input  logic          wr_hi,
  input  logic [DW-1:0] wdata,
  output logic [W-1:0]  cnt,
  output logic          step_evt,
  output logic          wrap_evt
);
  logic inc_eff;

  // any write to this counter drops a coincident strobe
  assign inc_eff  = inc & ~wr_lo & ~wr_hi;
  assign step_evt = inc_eff;
  assign wrap_evt = inc_eff & (&cnt);

  generate
    if (W > DW) begin : g_wide
      localparam int HI_W = W - DW;
      logic [DW-1:0] stage_q;

      always_ff @(posedge clk) begin
        if (rst) begin
          stage_q <= '0;
          cnt     <= '0;
        end else begin
          if (wr_lo) stage_q <= wdata;
          if (wr_hi)        cnt <= {wdata[HI_W-1:0], stage_q};
          else if (inc_eff) cnt <= cnt + 1'b1;
        end
      end
    end else begin : g_narrow
      always_ff @(posedge clk) begin
        if (rst)          cnt <= '0;
        else if (wr_lo)   cnt <= wdata[W-1:0];
        else if (inc_eff) cnt <= cnt + 1'b1;
      end
    end
  endgenerate
endmodule

// File: rtl/irq_ctl.sv
module irq_ctl #(
  parameter int N = 6
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [N-1:0] src,
  input  logic         mask_wr,
  input  logic         stat_wr,
  input  logic [N-1:0] wdata,
  output logic [N-1:0] mask_q,
  output logic [N-1:0] stat_q,
  output logic         irq_q
);
  logic [N-1:0] clr;
  logic [N-1:0] stat_d;

  always_comb begin
    clr    = stat_wr ? wdata : '0;
    stat_d = (stat_q & ~clr) | (src & mask_q);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      mask_q <= '0;
      stat_q <= '0;
      irq_q  <= 1'b0;
    end else begin
      if (mask_wr) mask_q <= wdata;
      stat_q <= stat_d;
      irq_q  <= |stat_d;
    end
  end
endmodule

// File: rtl/perf_err_bank.sv
module perf_err_bank
  import perf_err_pkg::*;
#(
  parameter int FAS_W  = 8,
  parameter int WIDE_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              fas_err_i,
  input  logic              ebit_err_i,
  input  logic              crc_err_i,
  input  logic              wr_en_i,
  input  logic              rd_en_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic              irq_o
);
  logic [FAS_W-1:0]   fas_cnt;
  logic [WIDE_W-1:0]  eb_cnt;
  logic [WIDE_W-1:0]  crc_cnt;
  logic [NUM_SRC-1:0] src;
  logic [NUM_SRC-1:0] irq_mask;
  logic [NUM_SRC-1:0] irq_stat;
  logic fas_step, fas_wrap, eb_step, eb_wrap, crc_step, crc_wrap;
  logic [DATA_W-1:0] rd_mux;

  logic w_fas, w_eb_lo, w_eb_hi, w_crc_lo, w_crc_hi, w_mask, w_stat;
  assign w_fas    = wr_en_i && addr_i == A_FAS;
  assign w_eb_lo  = wr_en_i && addr_i == A_EB_LO;
  assign w_eb_hi  = wr_en_i && addr_i == A_EB_HI;
  assign w_crc_lo = wr_en_i && addr_i == A_CRC_LO;
  assign w_crc_hi = wr_en_i && addr_i == A_CRC_HI;
  assign w_mask   = wr_en_i && addr_i == A_MASK;
  assign w_stat   = wr_en_i && addr_i == A_STAT;

  err_cnt #(.W(FAS_W), .DW(DATA_W)) u_fas (
    .clk(clk), .rst(rst), .inc(fas_err_i), .wr_lo(w_fas), .wr_hi(1'b0),
    .wdata(wdata_i), .cnt(fas_cnt), .step_evt(fas_step), .wrap_evt(fas_wrap)
  );

  err_cnt #(.W(WIDE_W), .DW(DATA_W)) u_eb (
    .clk(clk), .rst(rst), .inc(ebit_err_i), .wr_lo(w_eb_lo), .wr_hi(w_eb_hi),
    .wdata(wdata_i), .cnt(eb_cnt), .step_evt(eb_step), .wrap_evt(eb_wrap)
  );

  err_cnt #(.W(WIDE_W), .DW(DATA_W)) u_crc (
    .clk(clk), .rst(rst), .inc(crc_err_i), .wr_lo(w_crc_lo), .wr_hi(w_crc_hi),
    .wdata(wdata_i), .cnt(crc_cnt), .step_evt(crc_step), .wrap_evt(crc_wrap)
  );

  always_comb begin
    src = '0;
    src[S_FAS_STEP] = fas_step;
    src[S_FAS_WRAP] = fas_wrap;
    src[S_EB_STEP]  = eb_step;
    src[S_EB_WRAP]  = eb_wrap;
    src[S_CRC_STEP] = crc_step;
    src[S_CRC_WRAP] = crc_wrap;
  end

  irq_ctl #(.N(NUM_SRC)) u_irq (
    .clk(clk), .rst(rst), .src(src), .mask_wr(w_mask), .stat_wr(w_stat),
    .wdata(wdata_i[NUM_SRC-1:0]), .mask_q(irq_mask), .stat_q(irq_stat),
    .irq_q(irq_o)
  );

  always_comb begin
    case (addr_i)
      A_FAS:    rd_mux = DATA_W'(fas_cnt);
      A_EB_LO:  rd_mux = eb_cnt[DATA_W-1:0];
      A_EB_HI:  rd_mux = DATA_W'(eb_cnt >> DATA_W);
      A_CRC_LO: rd_mux = crc_cnt[DATA_W-1:0];
      A_CRC_HI: rd_mux = DATA_W'(crc_cnt >> DATA_W);
      A_MASK:   rd_mux = DATA_W'(irq_mask);
      A_STAT:   rd_mux = DATA_W'(irq_stat);
      default:  rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst)          rdata_o <= '0;
    else if (rd_en_i) rdata_o <= rd_mux;
  end
endmodule

// File: rtl/perf_err_chk.sv
module perf_err_chk (
  input logic        clk,
  input logic        rst,
  input logic        fas_err_i,
  input logic        crc_err_i,
  input logic        wr_en_i,
  input logic [2:0]  addr_i,
  input logic [7:0]  wdata_i,
  input logic [7:0]  fas_cnt,
  input logic [15:0] eb_cnt,
  input logic [15:0] crc_cnt,
  input logic [5:0]  irq_stat,
  input logic        irq_o
);
  AST_IRQ_MIRROR: assert property (@(posedge clk) disable iff (rst)
    irq_o == (|irq_stat)); // R8

  AST_FAS_STEP: assert property (@(posedge clk) disable iff (rst)
    (fas_err_i && !(wr_en_i && addr_i == 3'd0)) |=> fas_cnt == $past(fas_cnt) + 8'd1); // R2

  AST_FAS_HOLD: assert property (@(posedge clk) disable iff (rst)
    (!fas_err_i && !(wr_en_i && addr_i == 3'd0)) |=> $stable(fas_cnt)); // R2

  AST_WRITE_WINS: assert property (@(posedge clk) disable iff (rst)
    (fas_err_i && wr_en_i && addr_i == 3'd0) |=> fas_cnt == $past(wdata_i)); // R10

  AST_STAGE_HOLDS: assert property (@(posedge clk) disable iff (rst)
    (wr_en_i && addr_i == 3'd1) |=> $stable(eb_cnt)); // R9

  AST_CRC_STEP: assert property (@(posedge clk) disable iff (rst)
    (crc_err_i && !(wr_en_i && (addr_i == 3'd3 || addr_i == 3'd4)))
      |=> crc_cnt == $past(crc_cnt) + 16'd1); // R3
endmodule

bind perf_err_bank perf_err_chk u_chk (
  .clk(clk), .rst(rst), .fas_err_i(fas_err_i), .crc_err_i(crc_err_i),
  .wr_en_i(wr_en_i), .addr_i(addr_i), .wdata_i(wdata_i), .fas_cnt(fas_cnt),
  .eb_cnt(eb_cnt), .crc_cnt(crc_cnt), .irq_stat(irq_stat), .irq_o(irq_o)
);

// File: tb/sim_perf_err_bank.sv
`timescale 1ns/1ps
module sim_perf_err_bank;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic fas_err_i = 0, ebit_err_i = 0, crc_err_i = 0;
  logic wr_en_i = 0, rd_en_i = 0;
  logic [2:0] addr_i = '0;
  logic [7:0] wdata_i = '0;
  logic [7:0] rdata_o;
  logic irq_o;

  always #4 clk = ~clk;

  perf_err_bank u0 (
    .clk(clk), .rst(rst), .fas_err_i(fas_err_i), .ebit_err_i(ebit_err_i),
    .crc_err_i(crc_err_i), .wr_en_i(wr_en_i), .rd_en_i(rd_en_i),
    .addr_i(addr_i), .wdata_i(wdata_i), .rdata_o(rdata_o), .irq_o(irq_o)
  );

  int n_chk = 0, n_fail = 0;
  bit done = 0;

  logic [7:0]  m_fas;
  logic [15:0] m_eb, m_crc;
  logic [7:0]  m_ebs, m_crcs;
  logic [5:0]  m_mask, m_stat;

  task automatic chk(input int got, input int exp, input string tag);
    n_chk++;
    if (got != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", tag, got, exp);
    end
  endtask

  function automatic logic [7:0] model_rd(input logic [2:0] a);
    case (a)
      3'd0: return m_fas;
      3'd1: return m_eb[7:0];
      3'd2: return m_eb[15:8];
      3'd3: return m_crc[7:0];
      3'd4: return m_crc[15:8];
      3'd5: return {2'b00, m_mask};
      3'd6: return {2'b00, m_stat};
      default: return 8'h00;
    endcase
  endfunction

  task automatic model_upd(input logic [2:0] s, input logic w,
                           input logic [2:0] a, input logic [7:0] d);
    logic [5:0] ev = '0;
    logic kf = w && a == 3'd0;
    logic ke = w && (a == 3'd1 || a == 3'd2);
    logic kc = w && (a == 3'd3 || a == 3'd4);
    if (s[0] && !kf) begin ev[0] = 1; ev[1] = (m_fas == 8'hFF); m_fas = m_fas + 1; end
    if (s[1] && !ke) begin ev[2] = 1; ev[3] = (m_eb == 16'hFFFF); m_eb = m_eb + 1; end
    if (s[2] && !kc) begin ev[4] = 1; ev[5] = (m_crc == 16'hFFFF); m_crc = m_crc + 1; end
    if (kf) m_fas = d;
    if (w && a == 3'd2) m_eb = {d, m_ebs};
    if (w && a == 3'd1) m_ebs = d;
    if (w && a == 3'd4) m_crc = {d, m_crcs};
    if (w && a == 3'd3) m_crcs = d;
    m_stat = (m_stat & ~((w && a == 3'd6) ? d[5:0] : 6'd0)) | (ev & m_mask);
    if (w && a == 3'd5) m_mask = d[5:0];
  endtask

  task automatic cyc(input logic [2:0] s, input logic w, input logic r,
                     input logic [2:0] a, input logic [7:0] d, input string tag);
    logic [7:0] exp_rd;
    fas_err_i = s[0]; ebit_err_i = s[1]; crc_err_i = s[2];
    wr_en_i = w; rd_en_i = r; addr_i = a; wdata_i = d;
    exp_rd = model_rd(a);
    @(posedge clk);
    model_upd(s, w, a, d);
    @(negedge clk);
    fas_err_i = 0; ebit_err_i = 0; crc_err_i = 0; wr_en_i = 0; rd_en_i = 0;
    chk(irq_o, |m_stat, "R8 irq line");
    if (r) chk(rdata_o, exp_rd, tag);
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    cyc(3'b000, 1'b1, 1'b0, a, d, "");
  endtask
  task automatic rd(input logic [2:0] a, input string tag);
    cyc(3'b000, 1'b0, 1'b1, a, 8'h00, tag);
  endtask

  initial begin
    #1000000;
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5EED_0C11));
    m_fas = 0; m_eb = 0; m_crc = 0; m_ebs = 0; m_crcs = 0; m_mask = 0; m_stat = 0;
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);

    // R1 reset state
    chk(irq_o, 0, "R1 irq after reset");
    for (int i = 0; i < 8; i++) rd(3'(i), "R1 R11 reset readback");

    // R6 mask all on
    wr(3'd5, 8'hFF);
    rd(3'd5, "R6 mask readback upper bits zero");

    // R12 R2 R4 R5 fas wrap
    wr(3'd0, 8'hFE);
    rd(3'd0, "R12 fas direct load");
    cyc(3'b001, 0, 0, 3'd0, 8'h00, "");
    rd(3'd6, "R4 fas step status");
    cyc(3'b001, 0, 0, 3'd0, 8'h00, "");
    rd(3'd0, "R2 fas rolled to zero");
    rd(3'd6, "R5 fas wrap status");

    // R9 staged preset of E-bit counter
    wr(3'd1, 8'hFF);
    rd(3'd1, "R9 low write leaves counter");
    wr(3'd2, 8'hFF);
    rd(3'd1, "R9 preset low byte");
    rd(3'd2, "R9 preset high byte");
    cyc(3'b010, 0, 0, 3'd0, 8'h00, "");
    rd(3'd2, "R3 ebit rolled to zero");
    rd(3'd6, "R5 ebit wrap status");

    // R7 write-one-to-clear, set beats clear
    wr(3'd6, 8'h03);
    rd(3'd6, "R7 partial clear");
    cyc(3'b100, 1, 0, 3'd6, 8'hFF, "");
    rd(3'd6, "R7 set wins over clear");

    // R10 write drops strobe
    cyc(3'b001, 1, 0, 3'd0, 8'h55, "");
    rd(3'd0, "R10 write wins over strobe");
    cyc(3'b100, 1, 0, 3'd3, 8'h11, "");
    rd(3'd3, "R10 staging write drops crc strobe");
    rd(3'd6, "R10 no source on dropped strobe");

    // R6 masked sources
    wr(3'd6, 8'hFF);
    wr(3'd5, 8'h00);
    cyc(3'b111, 0, 0, 3'd0, 8'h00, "");
    rd(3'd6, "R6 masked sources leave status");
    chk(irq_o, 0, "R6 R8 irq low when masked");

    // random mix
    for (int i = 0; i < 600; i++) begin
      logic [2:0] s = 3'($urandom);
      logic w = ($urandom % 6) == 0;
      logic r = ($urandom % 2) == 0;
      logic [2:0] a = 3'($urandom % 7);
      logic [7:0] d = 8'($urandom);
      if (w && a == 3'd0 && ($urandom % 2) == 0) d = 8'hFF;
      cyc(s, w, r, a, d, "R11 random readback");
    end
    for (int i = 0; i < 7; i++) rd(3'(i), "R3 R11 final readback");

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule